// File: doc/BRIEF.md
# Power-Up and Master-Reset Initialization Sequencer

This block owns the start-up of a group of registers. When power is reported good, and again whenever an active-low master reset pin is held low long enough to count, it runs an initialization sequence of a fixed number of clock cycles. While the sequence runs the block raises a preload strobe. In the last few cycles of the sequence it pulses the set/reset term of every fast register that has one. All outputs stay disabled (high impedance) while the sequence runs. They are released only once the sequence is finished and the reset pin reads high.

The preload value for each register follows fixed rules:
- Fast-register value:
  - A fast register without a set/reset term loads high.
  - A fast register whose term is configured as set loads high.
  - A fast register whose term is configured as reset loads low.
- Standard-register value: a standard register loads its own configuration bit, whatever its set and reset terms are. An integrator who leaves that bit unspecified ties it to 0.

The reset pin passes through a two-flop synchronizer and a low-width filter, so a glitch cannot start a sequence. The length of the sequence stands in for supply monitoring and configuration loading.

The control flow is a four-state machine:
- States:
  - `ST_LOAD`: preload, before the term window.
  - `ST_TERM`: the last `TERM_CYCLES` of the sequence, when terms are pulsed.
  - `ST_WAIT`: the sequence is done but the reset pin is low.
  - `ST_READY`: outputs are enabled.
- Transitions:
  - `ST_LOAD` to `ST_TERM` when the cycle counter reaches `SEQ_CYCLES-TERM_CYCLES-1`.
  - `ST_TERM` to `ST_READY` on the last cycle if the pin is high, or to `ST_WAIT` if it is low.
  - `ST_WAIT` to `ST_READY` when the pin goes high.
  - `ST_READY` to `ST_WAIT` when the pin goes low.
  - Any state to `ST_LOAD`, with the counter cleared, on a qualified reset low. This has priority over all other transitions.
- Power-down (`pwr_good` low) forces `ST_LOAD` with the counter at zero.

Top module: `init_preload_seq`

## Requirements
- R1: After `pwr_good` rises with the reset pin high, `preload_strobe` stays high for `SEQ_CYCLES` cycles counted from the release, and then `out_en` goes high. While `pwr_good` is low, `out_en` is 0 and `preload_strobe` is 1.
- R2: `term_pulse[i]` is 1 only during the last `TERM_CYCLES` cycles of a sequence, and only for fast registers with `fast_term_used[i]`=1. During that window it is exactly `fast_term_used`.
- R3: `fast_preload_val[i]` follows these rules:
  - It is 1 when `fast_term_used[i]`=0.
  - When `fast_term_used[i]`=1, it equals `fast_term_is_set[i]` (1 = set term, 0 = reset term).
- R4: `std_preload_val[i]` equals `std_preload_cfg[i]` for every combination. An unspecified bit is tied to 0 and gives 0.
- R5: A low on `mrst_n` lasting at least `MIN_LOW` cycles starts a new sequence. The sequence starts at the edge `MIN_LOW+2` cycles after the pin falls (2 synchronizer stages plus the filter), and `preload_strobe` then stays high for `SEQ_CYCLES` cycles.
- R6: A low pulse shorter than `MIN_LOW` cycles starts no sequence. `out_en` returns high 3 cycles after the pin rises.
- R7: `out_en` is 0 two cycles after `mrst_n` falls, whether or not the low pulse is long enough to qualify.
- R8: If `mrst_n` stays low past the end of the sequence, `out_en` stays 0. It goes high 3 cycles after the pin rises.
- R9: A qualified reset low during a running sequence restarts it from cycle 0. The full `SEQ_CYCLES` then follows the restart.
- R10: At power-up with `mrst_n` held low, exactly one sequence runs and `out_en` stays 0 until the pin rises.
- R11: `out_en` and `preload_strobe` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good | input | 1 | Power-good indication; low acts as asynchronous reset |
| mrst_n | input | 1 | Asynchronous active-low master reset pin |
| fast_term_used | input | NUM_FAST | Per fast register: set/reset term defined |
| fast_term_is_set | input | NUM_FAST | Per fast register: 1 = term is set, 0 = term is reset |
| std_preload_cfg | input | NUM_STD | Per standard register: preload configuration bit |
| out_en | output | 1 | 1 = outputs driven, 0 = outputs high impedance |
| preload_strobe | output | 1 | High while the initialization sequence runs |
| fast_preload_val | output | NUM_FAST | Preload value for each fast register |
| std_preload_val | output | NUM_STD | Preload value for each standard register |
| term_pulse | output | NUM_FAST | Set/reset term assertion per fast register |

## Verification
The assertions check invariants on every cycle:
- The enable and strobe are never high together.
- Term pulses appear only inside a running sequence and only for registers with a term.
- The strobe ends only out of the term window.
- A qualified reset low puts the machine back to cycle 0 on the next edge.
- The low filter fires once per low period.

The bench scenarios are needed for the timing: the exact sequence length, the latency from the pin to the restart and to the enable release, the threshold between a filtered and a qualified pulse, restart in the middle of a sequence, and power-up with the pin held low. The preload rules are swept over every configuration.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;
    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_TERM  = 2'd1,
        ST_WAIT  = 2'd2,
        ST_READY = 2'd3
    } seq_state_t;
endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
    parameter int MIN_LOW = 4
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic pin_n,
    output logic pin_hi,
    output logic restart
);
    localparam int LOW_W = $clog2(MIN_LOW + 1);

    logic             s1, s2;
    logic [LOW_W-1:0] lowcnt;

    // Counter starts saturated so a pin already low at power-up is not a new event.
    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            s1     <= 1'b0;
            s2     <= 1'b0;
            lowcnt <= LOW_W'(MIN_LOW);
        end else begin
            s1 <= pin_n;
            s2 <= s1;
            if (s2)
                lowcnt <= '0;
            else if (lowcnt != LOW_W'(MIN_LOW))
                lowcnt <= lowcnt + 1'b1;
        end
    end

    assign pin_hi  = s2;
    assign restart = !s2 && (lowcnt == LOW_W'(MIN_LOW - 1));

    assert_lowcnt_bounded_R5: assert property (@(posedge clk) disable iff (!pwr_good)
        lowcnt <= LOW_W'(MIN_LOW));
    assert_one_restart_per_low_R5: assert property (@(posedge clk) disable iff (!pwr_good)
        restart |=> !restart);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import init_seq_pkg::*;
#(
    parameter int SEQ_CYCLES  = 16,
    parameter int TERM_CYCLES = 3
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic restart,
    input  logic pin_hi,
    output logic out_en,
    output logic busy,
    output logic term_active
);
    localparam int CNT_W     = $clog2(SEQ_CYCLES + 1);
    localparam int LAST_LOAD = SEQ_CYCLES - TERM_CYCLES - 1;
    localparam int LAST_SEQ  = SEQ_CYCLES - 1;

    seq_state_t       state, nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            ST_LOAD: begin
                cnt_nxt = cnt + 1'b1;
                if (cnt == CNT_W'(LAST_LOAD)) nxt = ST_TERM;
            end
            ST_TERM: begin
                if (cnt == CNT_W'(LAST_SEQ)) begin
                    cnt_nxt = '0;
                    nxt     = pin_hi ? ST_READY : ST_WAIT;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_WAIT:  if (pin_hi)  nxt = ST_READY;
            ST_READY: if (!pin_hi) nxt = ST_WAIT;
        endcase
        if (restart) begin
            nxt     = ST_LOAD;
            cnt_nxt = '0;
        end
    end

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            state <= ST_LOAD;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        busy        = (state == ST_LOAD) || (state == ST_TERM);
        term_active = (state == ST_TERM);
        out_en      = (state == ST_READY) && pin_hi;
    end

    assert_restart_to_zero_R9: assert property (@(posedge clk) disable iff (!pwr_good)
        restart |=> (state == ST_LOAD) && (cnt == '0));
    assert_end_from_term_R2: assert property (@(posedge clk) disable iff (!pwr_good)
        $fell(busy) |-> $past(state) == ST_TERM);
    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!pwr_good)
        cnt <= CNT_W'(LAST_SEQ));
endmodule

// File: rtl/preload_rules.sv
module preload_rules #(
    parameter int NUM_FAST = 4,
    parameter int NUM_STD  = 4
) (
    input  logic [NUM_FAST-1:0] term_used,
    input  logic [NUM_FAST-1:0] term_is_set,
    input  logic [NUM_STD-1:0]  std_cfg,
    input  logic                term_window,
    output logic [NUM_FAST-1:0] fast_val,
    output logic [NUM_STD-1:0]  std_val,
    output logic [NUM_FAST-1:0] term_pulse
);
    for (genvar i = 0; i < NUM_FAST; i++) begin : g_fast
        always_comb begin
            fast_val[i]   = term_used[i] ? term_is_set[i] : 1'b1;
            term_pulse[i] = term_used[i] && term_window;
        end
    end

    for (genvar j = 0; j < NUM_STD; j++) begin : g_std
        assign std_val[j] = std_cfg[j];
    end
endmodule

// File: rtl/init_preload_seq.sv
module init_preload_seq #(
    parameter int NUM_FAST    = 4,
    parameter int NUM_STD     = 4,
    parameter int SEQ_CYCLES  = 16,
    parameter int TERM_CYCLES = 3,
    parameter int MIN_LOW     = 4
) (
    input  logic                clk,
    input  logic                pwr_good,
    input  logic                mrst_n,
    input  logic [NUM_FAST-1:0] fast_term_used,
    input  logic [NUM_FAST-1:0] fast_term_is_set,
    input  logic [NUM_STD-1:0]  std_preload_cfg,
    output logic                out_en,
    output logic                preload_strobe,
    output logic [NUM_FAST-1:0] fast_preload_val,
    output logic [NUM_STD-1:0]  std_preload_val,
    output logic [NUM_FAST-1:0] term_pulse
);
    logic pin_hi, restart, term_active;

    rst_pin_filter #(.MIN_LOW(MIN_LOW)) u_filter (
        .clk     (clk),
        .pwr_good(pwr_good),
        .pin_n   (mrst_n),
        .pin_hi  (pin_hi),
        .restart (restart)
    );

    seq_fsm #(.SEQ_CYCLES(SEQ_CYCLES), .TERM_CYCLES(TERM_CYCLES)) u_fsm (
        .clk        (clk),
        .pwr_good   (pwr_good),
        .restart    (restart),
        .pin_hi     (pin_hi),
        .out_en     (out_en),
        .busy       (preload_strobe),
        .term_active(term_active)
    );

    preload_rules #(.NUM_FAST(NUM_FAST), .NUM_STD(NUM_STD)) u_rules (
        .term_used  (fast_term_used),
        .term_is_set(fast_term_is_set),
        .std_cfg    (std_preload_cfg),
        .term_window(term_active),
        .fast_val   (fast_preload_val),
        .std_val    (std_preload_val),
        .term_pulse (term_pulse)
    );

    assert_no_enable_while_loading_R11: assert property (@(posedge clk) disable iff (!pwr_good)
        !(out_en && preload_strobe));
    assert_term_inside_sequence_R2: assert property (@(posedge clk) disable iff (!pwr_good)
        (term_pulse != '0) |-> preload_strobe);
    assert_term_only_if_used_R2: assert property (@(posedge clk) disable iff (!pwr_good)
        (term_pulse & ~fast_term_used) == '0);
endmodule

// File: tb/tb_init_preload_seq.sv
module tb_init_preload_seq;
    localparam int NF = 4, NS = 4, SEQ = 16, K = 3, ML = 4;

    logic clk = 1'b0;
    logic pwr_good = 1'b0, mrst_n = 1'b1;
    logic [NF-1:0] fast_used = '0, fast_set = '0;
    logic [NS-1:0] std_cfg = '0;
    logic out_en, strobe;
    logic [NF-1:0] fval, term;
    logic [NS-1:0] sval;

    int checks = 0, errors = 0;
    int p_nb, p_nt, p_lb, p_lt, p_rise, p_en2, p_bad;

    always #2.5 clk = ~clk;

    init_preload_seq #(.NUM_FAST(NF), .NUM_STD(NS), .SEQ_CYCLES(SEQ),
                       .TERM_CYCLES(K), .MIN_LOW(ML)) dut (
        .clk(clk), .pwr_good(pwr_good), .mrst_n(mrst_n),
        .fast_term_used(fast_used), .fast_term_is_set(fast_set),
        .std_preload_cfg(std_cfg), .out_en(out_en), .preload_strobe(strobe),
        .fast_preload_val(fval), .std_preload_val(sval), .term_pulse(term));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Observe win negedges; raise mrst_n after sample number rel (0 = never).
    task automatic obs(input int win, input int rel);
        p_nb = 0; p_nt = 0; p_lb = 0; p_lt = 0; p_rise = 0; p_en2 = -1; p_bad = 0;
        for (int i = 1; i <= win; i++) begin
            @(negedge clk);
            if (strobe) begin p_nb++; p_lb = i; end
            if (term != '0) begin
                p_nt++; p_lt = i;
                if (term != fast_used) p_bad++;
            end
            if (out_en && strobe) p_bad++;
            if (i == 2) p_en2 = int'(out_en);
            if (i >= 2 && out_en && p_rise == 0) p_rise = i;
            if (i == rel) mrst_n = 1'b1;
        end
    endtask

    task automatic pulse(input int L);
        mrst_n = 1'b0;
        obs(ML + SEQ + L + 8, L);
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        fast_used = 4'b0110;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_en == 1'b0, "R1 reset out_en", int'(out_en), 0);
        chk(strobe == 1'b1, "R1 reset strobe", int'(strobe), 1);

        // R1/R2: power-up, pin high; first sample after first edge
        pwr_good = 1'b1;
        obs(SEQ + 6, 0);
        chk(p_nb == SEQ - 1, "R1 busy length", p_nb, SEQ - 1);
        chk(p_rise == SEQ, "R1 enable time", p_rise, SEQ);
        chk(p_nt == K, "R2 term length", p_nt, K);
        chk(p_lt == p_lb, "R2 term at end", p_lt, p_lb);
        chk(p_bad == 0, "R2 term mask / R11 overlap", p_bad, 0);

        // R5 R6 R7: sweep pulse widths across the filter threshold
        for (int L = 1; L <= ML + 2; L++) begin
            pulse(L);
            chk(p_en2 == 0, "R7 enable drop", p_en2, 0);
            chk(p_bad == 0, "R2 term mask / R11 overlap", p_bad, 0);
            if (L < ML) begin
                chk(p_nb == 0, "R6 short pulse ignored", p_nb, 0);
                chk(p_rise == L + 3, "R6 enable return", p_rise, L + 3);
            end else begin
                chk(p_nb == SEQ, "R5 sequence length", p_nb, SEQ);
                chk(p_lb == ML + 1 + SEQ, "R5 sequence timing", p_lb, ML + 1 + SEQ);
                chk(p_nt == K && p_lt == p_lb, "R2 term window", p_nt, K);
                chk(p_rise == imax(ML + 2 + SEQ, L + 3), "R5 enable time", p_rise,
                    imax(ML + 2 + SEQ, L + 3));
            end
        end

        // R8: pin held low past the end of the sequence
        pulse(ML + SEQ + 6);
        chk(p_nb == SEQ, "R8 one sequence", p_nb, SEQ);
        chk(p_rise == ML + SEQ + 9, "R8 enable after pin high", p_rise, ML + SEQ + 9);

        // R9: restart in the middle of a running sequence
        mrst_n = 1'b0;
        obs(ML + 6, ML);
        chk(strobe == 1'b1 && p_nt == 0, "R9 sequence running", p_nt, 0);
        pulse(ML);
        chk(p_nb == ML + 1 + SEQ, "R9 restart length", p_nb, ML + 1 + SEQ);
        chk(p_nt == K && p_lt == p_lb, "R9 term once at end", p_nt, K);
        chk(p_rise == ML + 2 + SEQ, "R9 enable time", p_rise, ML + 2 + SEQ);

        // R10: power-up with pin held low
        @(negedge clk);
        pwr_good = 1'b0; mrst_n = 1'b0;
        repeat (2) @(negedge clk);
        pwr_good = 1'b1;
        obs(SEQ + 10, 0);
        chk(p_nb == SEQ - 1, "R10 single sequence", p_nb, SEQ - 1);
        chk(p_rise == 0, "R10 enable held", p_rise, 0);
        mrst_n = 1'b1;
        obs(6, 0);
        chk(p_rise == 3, "R10 enable after pin high", p_rise, 3);

        // R3: all fast configurations
        for (int a = 0; a < 256; a++) begin
            logic [NF-1:0] exp;
            fast_used = a[3:0]; fast_set = a[7:4];
            #1;
            for (int b = 0; b < NF; b++) exp[b] = fast_used[b] ? fast_set[b] : 1'b1;
            chk(fval == exp, "R3 fast preload", int'(fval), int'(exp));
        end
        // R4: all standard configurations (0 = unspecified default)
        for (int c = 0; c < 16; c++) begin
            std_cfg = c[3:0];
            #1;
            chk(sval == c[3:0], "R4 std preload", int'(sval), c);
        end
        chk(out_en == 1'b1 && strobe == 1'b0, "R11 idle state", int'(out_en), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule